// File: doc/BRIEF.md
# Scaler Pool Allocator

This block shares a small pool of image scalers among several display users. The default is nine users: eight plane users and one pipe-fitter user. Software or a sequencer describes each user in turn with a request that carries four things: source width and height, destination width and height, and a flag that marks a planar YUV source. A user can also give up its scaler with a release. Requests change only the stored description and the set of users that need a scaler.

A start pulse launches an allocation pass. The pass first counts the users that need a scaler and fails at once when there are more of them than scalers. Otherwise it walks the users in ascending index order, one user per clock. A user that already owns a scaler keeps it. A user without one takes the lowest-numbered free scaler. When exactly one user needs a scaler and the pool has more than one, that user is moved to scaler 0, which runs in high-quality mode.

Each user is checked against the size and scale limits before its assignment is committed. The pass ends with a one-cycle done pulse and an error flag that stays set until the next start. Requests and start pulses that arrive while a pass runs are dropped.

Top module: `scaler_alloc`

## Requirements
- R1: After reset no user owns a scaler, every user id reads 0, every scaler mode reads idle (2'b00), and busy, done and err are low.
- R2: A request needs a scaler when its source size differs from its destination size or its planar flag is set. A request that needs none acts as a release. A release clears the user's need and frees the scaler it owned, which turns that user's valid bit low and that scaler's mode to idle (2'b00).
- R3: When a start finds more users that need a scaler than there are scalers, err and done rise on the next cycle and no assignment changes.
- R4: Users are processed in ascending index order. A user that already owns a scaler keeps it, and a user without one takes the lowest-numbered free scaler. No two users own the same scaler.
- R5: When exactly one user needs a scaler and NUM_SCALERS > 1, that user owns scaler 0 in high-quality mode (2'b10). Every other assigned scaler runs in dynamic mode (2'b01).
- R6: Source width and height must each be at least 8, or at least 16 when the planar flag is set. Destination width and height must each be at least 8. A violation sets err.
- R7: Source and destination widths must not exceed MAX_W, and heights must not exceed MAX_H. A violation sets err.
- R8: The horizontal ratio source/destination must be below 3.0. When NEW_MODE = 0, a planar source must stay below 2.0 on both axes. A violation sets err.
- R9: When NEW_MODE = 1, a user on any scaler other than 0 needs source height no larger than destination height. Scaler 0 and horizontal limits stay at 3.0, planar included.
- R10: While interlaced is high, any user that needs a scaler makes the pass fail with err.
- R11: done pulses for exactly one cycle, NUM_USERS cycles after the cycle that accepted start, when no error stops the pass earlier. err stays high until the next accepted start and is cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request or release strobe, taken when idle |
| req_release | input | 1 | 1: release the user, 0: describe the user |
| req_user | input | UID_W | User index |
| req_src_w | input | DIM_W | Source width |
| req_src_h | input | DIM_W | Source height |
| req_dst_w | input | DIM_W | Destination width |
| req_dst_h | input | DIM_W | Destination height |
| req_planar | input | 1 | Source is planar YUV |
| interlaced | input | 1 | Timing is interlaced |
| start | input | 1 | Launch an allocation pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| err | output | 1 | Last pass failed, held until the next start |
| user_vld | output | NUM_USERS | User owns a scaler |
| user_sid | output | NUM_USERS*SID_W | Scaler id of each user, user u at bits [u*SID_W +: SID_W] |
| scaler_mode | output | NUM_SCALERS*2 | Mode of each scaler, scaler s at bits [2s+1:2s] |

## Verification
The bench builds two copies of the block that share every input. Both use nine users, two scalers, 12-bit dimensions, MAX_W = 1024 and MAX_H = 512. The smaller maxima put the width and height limits a single step from legal sizes. One copy has NEW_MODE = 0 and the other NEW_MODE = 1, so one stimulus shows the planar 2.0 limit against the vertical rule on scaler 1. Two scalers make both the high-quality move to scaler 0 and the overcommit failure reachable with only two or three users.

// File: rtl/scl_alloc_pkg.sv
package scl_alloc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_DYN = 2'b01,
        MODE_HQ  = 2'b10
    } scl_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/scl_popcount.sv
module scl_popcount #(
    parameter int W     = 9,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits_in,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CNT_W'(bits_in[i]);
        end
    end
endmodule

// File: rtl/scl_first_free.sv
module scl_first_free #(
    parameter int NS    = 2,
    parameter int SID_W = 1
) (
    input  logic [NS-1:0]    in_use,
    output logic             found,
    output logic [SID_W-1:0] sid
);
    // walk from the top so the lowest free index is the last one written
    always_comb begin
        found = 1'b0;
        sid   = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (!in_use[i]) begin
                found = 1'b1;
                sid   = SID_W'(i);
            end
        end
    end
endmodule

// File: rtl/scl_limit_check.sv
module scl_limit_check #(
    parameter int DIM_W    = 14,
    parameter int MAX_W    = 4096,
    parameter int MAX_H    = 4096,
    parameter bit NEW_MODE = 1'b0
) (
    input  logic [DIM_W-1:0] src_w,
    input  logic [DIM_W-1:0] src_h,
    input  logic [DIM_W-1:0] dst_w,
    input  logic [DIM_W-1:0] dst_h,
    input  logic             planar,
    input  logic             on_first,
    output logic             ok
);
    localparam int EW = DIM_W + 2;
    localparam logic [DIM_W-1:0] MIN_PLAIN = DIM_W'(8);
    localparam logic [DIM_W-1:0] MIN_PLNR  = DIM_W'(16);
    localparam logic [DIM_W-1:0] LIM_W     = DIM_W'(MAX_W);
    localparam logic [DIM_W-1:0] LIM_H     = DIM_W'(MAX_H);

    logic [DIM_W-1:0] src_min;
    logic [EW-1:0]    sw_x, sh_x, dw2, dw3, dh2, dh3;
    logic             min_ok, max_ok, h_ok, v_ok, legacy_planar;

    always_comb begin
        src_min       = planar ? MIN_PLNR : MIN_PLAIN;
        legacy_planar = planar && !NEW_MODE;
        sw_x = EW'(src_w);
        sh_x = EW'(src_h);
        dw2  = EW'(dst_w) << 1;
        dh2  = EW'(dst_h) << 1;
        dw3  = dw2 + EW'(dst_w);
        dh3  = dh2 + EW'(dst_h);

        min_ok = (src_w >= src_min) && (src_h >= src_min) &&
                 (dst_w >= MIN_PLAIN) && (dst_h >= MIN_PLAIN);
        max_ok = (src_w <= LIM_W) && (dst_w <= LIM_W) &&
                 (src_h <= LIM_H) && (dst_h <= LIM_H);

        // ratio below k  <=>  src < k * dst (integer sizes)
        h_ok = legacy_planar ? (sw_x < dw2) : (sw_x < dw3);
        if (NEW_MODE && !on_first) begin
            v_ok = (src_h <= dst_h);
        end else begin
            v_ok = legacy_planar ? (sh_x < dh2) : (sh_x < dh3);
        end
        ok = min_ok && max_ok && h_ok && v_ok;
    end
endmodule

// File: rtl/scaler_alloc.sv
module scaler_alloc
    import scl_alloc_pkg::*;
#(
    parameter int NUM_USERS   = 9,
    parameter int NUM_SCALERS = 2,
    parameter int DIM_W       = 14,
    parameter int MAX_W       = 4096,
    parameter int MAX_H       = 4096,
    parameter bit NEW_MODE    = 1'b0,
    localparam int UID_W      = $clog2(NUM_USERS),
    localparam int SID_W      = (NUM_SCALERS > 1) ? $clog2(NUM_SCALERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_release,
    input  logic [UID_W-1:0]             req_user,
    input  logic [DIM_W-1:0]             req_src_w,
    input  logic [DIM_W-1:0]             req_src_h,
    input  logic [DIM_W-1:0]             req_dst_w,
    input  logic [DIM_W-1:0]             req_dst_h,
    input  logic                         req_planar,
    input  logic                         interlaced,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         err,
    output logic [NUM_USERS-1:0]         user_vld,
    output logic [NUM_USERS*SID_W-1:0]   user_sid,
    output logic [NUM_SCALERS*2-1:0]     scaler_mode
);
    localparam int CNT_W = $clog2(NUM_USERS + 1);
    localparam logic [CNT_W-1:0] NS_V     = CNT_W'(NUM_SCALERS);
    localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);
    localparam logic [UID_W-1:0] LAST_IDX = UID_W'(NUM_USERS - 1);
    localparam logic [UID_W:0]   NU_V     = (UID_W + 1)'(NUM_USERS);
    localparam bit               MULTI    = (NUM_SCALERS > 1);

    typedef struct packed {
        scan_state_e                            st;
        logic [UID_W-1:0]                       idx;
        logic                                   done;
        logic                                   err;
        logic                                   single;
        logic [NUM_USERS-1:0]                   mask;
        logic [NUM_USERS-1:0]                   vld;
        logic [NUM_USERS-1:0][SID_W-1:0]        sid;
        logic [NUM_USERS-1:0][DIM_W-1:0]        src_w;
        logic [NUM_USERS-1:0][DIM_W-1:0]        src_h;
        logic [NUM_USERS-1:0][DIM_W-1:0]        dst_w;
        logic [NUM_USERS-1:0][DIM_W-1:0]        dst_h;
        logic [NUM_USERS-1:0]                   planar;
        logic [NUM_SCALERS-1:0]                 in_use;
        scl_mode_e [NUM_SCALERS-1:0]            mode;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    logic [CNT_W-1:0] need_cnt;
    logic             free_found;
    logic [SID_W-1:0] free_sid;
    logic [SID_W-1:0] tgt_sid;
    logic             tgt_ok;
    logic             lim_ok;
    logic [NUM_USERS-1:0] user_mask;

    assign user_mask = st_q.mask;

    scl_popcount #(.W(NUM_USERS), .CNT_W(CNT_W)) u_pop (
        .bits_in (st_q.mask),
        .count   (need_cnt)
    );

    scl_first_free #(.NS(NUM_SCALERS), .SID_W(SID_W)) u_free (
        .in_use (st_q.in_use),
        .found  (free_found),
        .sid    (free_sid)
    );

    // scaler the user under scan would land on
    always_comb begin
        if (st_q.single && MULTI) begin
            tgt_sid = '0;
            tgt_ok  = 1'b1;
        end else if (st_q.vld[st_q.idx]) begin
            tgt_sid = st_q.sid[st_q.idx];
            tgt_ok  = 1'b1;
        end else begin
            tgt_sid = free_sid;
            tgt_ok  = free_found;
        end
    end

    scl_limit_check #(
        .DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .NEW_MODE(NEW_MODE)
    ) u_lim (
        .src_w    (st_q.src_w[st_q.idx]),
        .src_h    (st_q.src_h[st_q.idx]),
        .dst_w    (st_q.dst_w[st_q.idx]),
        .dst_h    (st_q.dst_h[st_q.idx]),
        .planar   (st_q.planar[st_q.idx]),
        .on_first (tgt_sid == '0),
        .ok       (lim_ok)
    );

    always_comb begin
        logic need;
        logic fail;
        st_d      = st_q;
        st_d.done = 1'b0;
        need      = 1'b0;
        fail      = 1'b0;
        if (st_q.st == ST_IDLE) begin
            if (req_valid && ({1'b0, req_user} < NU_V)) begin
                need = req_planar || (req_src_w != req_dst_w) ||
                       (req_src_h != req_dst_h);
                if (req_release || !need) begin
                    st_d.mask[req_user] = 1'b0;
                    if (st_q.vld[req_user]) begin
                        st_d.vld[req_user]                  = 1'b0;
                        st_d.in_use[st_q.sid[req_user]]     = 1'b0;
                        st_d.mode[st_q.sid[req_user]]       = MODE_OFF;
                    end
                end else begin
                    st_d.mask[req_user]   = 1'b1;
                    st_d.src_w[req_user]  = req_src_w;
                    st_d.src_h[req_user]  = req_src_h;
                    st_d.dst_w[req_user]  = req_dst_w;
                    st_d.dst_h[req_user]  = req_dst_h;
                    st_d.planar[req_user] = req_planar;
                end
            end
            if (start) begin
                st_d.err = 1'b0;
                if (need_cnt > NS_V) begin
                    st_d.err  = 1'b1;
                    st_d.done = 1'b1;
                end else begin
                    st_d.st     = ST_SCAN;
                    st_d.idx    = '0;
                    st_d.single = (need_cnt == ONE_V);
                end
            end
        end else begin
            if (st_q.mask[st_q.idx]) begin
                if (interlaced || !tgt_ok || !lim_ok) begin
                    fail = 1'b1;
                end else begin
                    if (st_q.vld[st_q.idx] && (st_q.sid[st_q.idx] != tgt_sid)) begin
                        st_d.in_use[st_q.sid[st_q.idx]] = 1'b0;
                        st_d.mode[st_q.sid[st_q.idx]]   = MODE_OFF;
                    end
                    st_d.vld[st_q.idx]  = 1'b1;
                    st_d.sid[st_q.idx]  = tgt_sid;
                    st_d.in_use[tgt_sid] = 1'b1;
                    st_d.mode[tgt_sid]   = (st_q.single && MULTI) ? MODE_HQ : MODE_DYN;
                end
            end
            if (fail) begin
                st_d.err  = 1'b1;
                st_d.done = 1'b1;
                st_d.st   = ST_IDLE;
            end else if (st_q.idx == LAST_IDX) begin
                st_d.done = 1'b1;
                st_d.st   = ST_IDLE;
            end else begin
                st_d.idx = st_q.idx + UID_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.st == ST_SCAN);
    assign done        = st_q.done;
    assign err         = st_q.err;
    assign user_vld    = st_q.vld;
    assign user_sid    = st_q.sid;
    assign scaler_mode = st_q.mode;
endmodule

// File: rtl/scaler_alloc_chk.sv
module scaler_alloc_chk #(
    parameter int NUM_USERS   = 9,
    parameter int NUM_SCALERS = 2,
    localparam int UID_W      = $clog2(NUM_USERS),
    localparam int SID_W      = (NUM_SCALERS > 1) ? $clog2(NUM_SCALERS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       busy,
    input logic                       done,
    input logic                       err,
    input logic                       req_valid,
    input logic                       req_release,
    input logic [UID_W-1:0]           req_user,
    input logic [NUM_USERS-1:0]       user_vld,
    input logic [NUM_USERS*SID_W-1:0] user_sid,
    input logic [NUM_SCALERS*2-1:0]   scaler_mode,
    input logic [NUM_USERS-1:0]       user_mask
);
    logic shared_sid;
    logic hq_high;

    always_comb begin
        shared_sid = 1'b0;
        for (int a = 0; a < NUM_USERS; a++) begin
            for (int b = a + 1; b < NUM_USERS; b++) begin
                if (user_vld[a] && user_vld[b] &&
                    (user_sid[a*SID_W +: SID_W] == user_sid[b*SID_W +: SID_W])) begin
                    shared_sid = 1'b1;
                end
            end
        end
        hq_high = 1'b0;
        for (int s = 1; s < NUM_SCALERS; s++) begin
            if (scaler_mode[2*s +: 2] == 2'b10) begin
                hq_high = 1'b1;
            end
        end
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_overcommit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && ($countones(user_mask) > NUM_SCALERS)) |=> (err && done));

    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_release && (int'(req_user) < NUM_USERS))
        |=> !user_vld[$past(req_user)]);

    assert_owner_needs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (user_vld & ~user_mask) == '0);

    assert_unique_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_sid);

    assert_hq_first_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hq_high);
endmodule

bind scaler_alloc scaler_alloc_chk #(
    .NUM_USERS   (NUM_USERS),
    .NUM_SCALERS (NUM_SCALERS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .req_valid   (req_valid),
    .req_release (req_release),
    .req_user    (req_user),
    .user_vld    (user_vld),
    .user_sid    (user_sid),
    .scaler_mode (scaler_mode),
    .user_mask   (user_mask)
);

// File: tb/test_scaler_alloc.sv
`timescale 1ns/1ps
module test_scaler_alloc;
    localparam int NU  = 9;
    localparam int NS  = 2;
    localparam int DW  = 12;
    localparam int UW  = 4;
    localparam int SW  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_release = 1'b0;
    logic [UW-1:0] req_user = '0;
    logic [DW-1:0] req_src_w = '0, req_src_h = '0, req_dst_w = '0, req_dst_h = '0;
    logic          req_planar = 1'b0;
    logic          interlaced = 1'b0;
    logic          start = 1'b0;

    logic          busy, done, err;
    logic [NU-1:0] user_vld;
    logic [NU*SW-1:0] user_sid;
    logic [NS*2-1:0]  scaler_mode;
    logic          busy_n, done_n, err_n;
    logic [NU-1:0] user_vld_n;
    logic [NU*SW-1:0] user_sid_n;
    logic [NS*2-1:0]  scaler_mode_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scaler_alloc #(.NUM_USERS(NU), .NUM_SCALERS(NS), .DIM_W(DW),
                   .MAX_W(1024), .MAX_H(512), .NEW_MODE(1'b0)) i_scaler_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_release(req_release),
        .req_user(req_user), .req_src_w(req_src_w), .req_src_h(req_src_h),
        .req_dst_w(req_dst_w), .req_dst_h(req_dst_h), .req_planar(req_planar),
        .interlaced(interlaced), .start(start), .busy(busy), .done(done), .err(err),
        .user_vld(user_vld), .user_sid(user_sid), .scaler_mode(scaler_mode));

    scaler_alloc #(.NUM_USERS(NU), .NUM_SCALERS(NS), .DIM_W(DW),
                   .MAX_W(1024), .MAX_H(512), .NEW_MODE(1'b1)) i_scaler_alloc_nm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_release(req_release),
        .req_user(req_user), .req_src_w(req_src_w), .req_src_h(req_src_h),
        .req_dst_w(req_dst_w), .req_dst_h(req_dst_h), .req_planar(req_planar),
        .interlaced(interlaced), .start(start), .busy(busy_n), .done(done_n), .err(err_n),
        .user_vld(user_vld_n), .user_sid(user_sid_n), .scaler_mode(scaler_mode_n));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sid_of(input int u);
        return int'(user_sid[u*SW +: SW]);
    endfunction

    task automatic do_req(input int u, input int sw, input int sh, input int dw,
                          input int dh, input bit pl);
        @(negedge clk);
        req_valid = 1'b1; req_release = 1'b0; req_user = UW'(u);
        req_src_w = DW'(sw); req_src_h = DW'(sh);
        req_dst_w = DW'(dw); req_dst_h = DW'(dh); req_planar = pl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_rel(input int u);
        @(negedge clk);
        req_valid = 1'b1; req_release = 1'b1; req_user = UW'(u);
        @(negedge clk);
        req_valid = 1'b0; req_release = 1'b0;
    endtask

    task automatic clean();
        for (int u = 0; u < NU; u++) do_rel(u);
    endtask

    // returns the number of negedges waited after the one where start drops
    task automatic run_scan(output int waits);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waits = 0;
        while (!done && waits < 40) begin
            @(negedge clk);
            waits++;
        end
        while (busy_n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 user_vld", int'(user_vld), 0);
        chk("R1 user_sid", int'(user_sid), 0);
        chk("R1 scaler_mode", int'(scaler_mode), 0);
    endtask

    task automatic t_hq_and_order();
        int w;
        do_req(3, 100, 100, 200, 200, 1'b0);
        run_scan(w);
        chk("R5 single err", int'(err), 0);
        chk("R5 single vld", int'(user_vld[3]), 1);
        chk("R5 single sid", sid_of(3), 0);
        chk("R5 single mode HQ", int'(scaler_mode), 2);
        do_req(1, 100, 100, 150, 150, 1'b0);
        run_scan(w);
        chk("R4 newcomer takes free scaler 1", sid_of(1), 1);
        chk("R4 owner keeps scaler 0", sid_of(3), 0);
        chk("R5 both dynamic", int'(scaler_mode), 5);
        clean();
        do_req(5, 64, 64, 32, 32, 1'b0);
        do_req(2, 64, 64, 128, 128, 1'b0);
        run_scan(w);
        chk("R4 ascending lower user", sid_of(2), 0);
        chk("R4 ascending higher user", sid_of(5), 1);
    endtask

    task automatic t_overcommit_release();
        int w;
        do_req(7, 50, 50, 60, 60, 1'b0);
        run_scan(w);
        chk("R3 overcommit err", int'(err), 1);
        chk("R3 overcommit no assign", int'(user_vld[7]), 0);
        chk("R3 others unchanged", sid_of(5), 1);
        repeat (3) @(negedge clk);
        chk("R11 err held", int'(err), 1);
        do_rel(7);
        run_scan(w);
        chk("R11 err cleared by start", int'(err), 0);
        do_rel(5);
        chk("R2 release clears vld", int'(user_vld[5]), 0);
        chk("R2 release idles scaler 1", int'(scaler_mode), 1);
        do_req(2, 64, 64, 64, 64, 1'b0);
        chk("R2 same size acts as release", int'(user_vld[2]), 0);
        chk("R2 all idle", int'(scaler_mode), 0);
        do_req(4, 64, 64, 64, 64, 1'b1);
        run_scan(w);
        chk("R2 planar same size needs scaler", int'(user_vld[4]), 1);
        chk("R2 planar mode HQ", int'(scaler_mode), 2);
        clean();
    endtask

    task automatic one_user(input string tag, input int sw, input int sh,
                            input int dw, input int dh, input bit pl,
                            input int exp_leg, input int exp_new);
        int w;
        clean();
        do_req(0, sw, sh, dw, dh, pl);
        run_scan(w);
        chk({tag, " legacy err"}, int'(err), exp_leg);
        if (exp_new >= 0) chk({tag, " newmode err"}, int'(err_n), exp_new);
    endtask

    task automatic t_limits();
        one_user("R6 src width 7", 7, 100, 100, 100, 1'b0, 1, -1);
        one_user("R6 src 8x8 legal", 8, 8, 16, 16, 1'b0, 0, -1);
        one_user("R6 planar src 15", 15, 32, 32, 32, 1'b1, 1, -1);
        one_user("R6 planar src 16 legal", 16, 16, 32, 32, 1'b1, 0, -1);
        one_user("R7 src width 1025", 1025, 100, 1000, 100, 1'b0, 1, -1);
        one_user("R7 at maxima legal", 1000, 500, 1024, 512, 1'b0, 0, -1);
        one_user("R7 dst height 513", 500, 500, 500, 513, 1'b0, 1, -1);
        one_user("R8 hratio 3.0", 300, 100, 100, 100, 1'b0, 1, -1);
        one_user("R8 hratio 2.99", 299, 100, 100, 100, 1'b0, 0, -1);
        one_user("R8 vratio 3.0", 100, 300, 100, 100, 1'b0, 1, -1);
        one_user("R8 planar hratio 2.0", 200, 100, 100, 100, 1'b1, 1, 0);
        one_user("R8 planar hratio 1.99", 199, 100, 100, 100, 1'b1, 0, 0);
        one_user("R9 scaler0 vratio 2.0", 100, 200, 100, 100, 1'b0, 0, 0);
    endtask

    task automatic t_newmode();
        int w;
        clean();
        do_req(0, 100, 100, 200, 200, 1'b0);
        do_req(1, 100, 101, 100, 100, 1'b0);
        run_scan(w);
        chk("R9 legacy scaler1 vdown ok", int'(err), 0);
        chk("R9 newmode scaler1 vdown err", int'(err_n), 1);
        clean();
        do_req(0, 100, 100, 200, 200, 1'b0);
        do_req(1, 100, 100, 50, 100, 1'b0);
        run_scan(w);
        chk("R9 newmode scaler1 equal height ok", int'(err_n), 0);
        chk("R9 newmode user1 on scaler 1", int'(user_sid_n[1]), 1);
    endtask

    task automatic t_interlace();
        int w;
        clean();
        interlaced = 1'b1;
        run_scan(w);
        chk("R10 interlaced with no users", int'(err), 0);
        do_req(0, 100, 100, 200, 200, 1'b0);
        run_scan(w);
        chk("R10 interlaced scaling rejected", int'(err), 1);
        chk("R10 no assignment", int'(user_vld[0]), 0);
        interlaced = 1'b0;
    endtask

    task automatic t_done();
        int w;
        clean();
        do_req(6, 100, 100, 120, 120, 1'b0);
        run_scan(w);
        chk("R11 done latency", w, NU);
        chk("R11 pass ok", int'(err), 0);
        @(negedge clk);
        chk("R11 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hq_and_order();
        t_overcommit_release();
        t_limits();
        t_newmode();
        t_interlace();
        t_done();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule